// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes one PWM waveform and places it on any mix of four output pins. A small control register holds a four-bit steering mask, with one bit per pin, and a sync-mode bit. A pin whose mask bit is set carries the PWM waveform, at the level that a two-bit polarity selector picks. A pin whose mask bit is clear passes its own bit of general-purpose port data. The same waveform can appear on one, two, three or all four pins at once.

A new mask can take effect at once, one clock after the register write. It can also be held back and loaded on the next PWM period-start strobe, so the pin set never changes in the middle of a period. Steering acts only while a mode-qualify input says single-output mode is active. An auto-shutdown request drives every steered pin to its inactive level and leaves unsteered pins on port data. Read-back returns the value last written to the register, not the mask now driving the pins.

Top module: `pwm_steer_unit`

## Requirements
- R1: After reset, `rd_data` reads 0x01 and the active mask steers pin A (`pin_out[0]`) only.
- R2: One clock after a write, `rd_data` equals the written byte with bits 7..5 forced to 0. Bits 7..5 always read 0.
- R3: A write with bit 4 (sync) clear loads `wr_data[3:0]` into the active mask at that clock edge, so the pins change from the next cycle on.
- R4: A write with bit 4 set leaves the active mask unchanged. The stored mask is loaded at the first clock edge where `period_start` is high, and the pins change from the next cycle on. An immediate write in the same cycle takes priority.
- R5: While a synchronous update is pending, `rd_data` shows the pending register value, not the active mask.
- R6: A pin whose active mask bit is 0 outputs its `port_data` bit.
- R7: A steered pin outputs `pwm_in` XOR its inversion bit. `pol_sel[1]` inverts pins A and C (indices 0, 2) and `pol_sel[0]` inverts pins B and D (indices 1, 3).
- R8: Any combination of mask bits steers those pins at the same time, each with its own polarity.
- R9: With `single_mode` low, every pin outputs `port_data`, whatever the mask, polarity or shutdown inputs.
- R10: With `shutdown` high, each steered pin drives its inactive level, which equals its inversion bit. Unsteered pins keep `port_data`.
- R11: Register bits 3..0 steer pins D, C, B, A in that order, so mask bit i drives `pin_out[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value: bit 4 sync, bits 3..0 mask |
| rd_data | output | 8 | Register read-back |
| pwm_in | input | 1 | Raw PWM waveform |
| period_start | input | 1 | Strobe at the start of each PWM period |
| single_mode | input | 1 | High when single-output PWM mode is active |
| pol_sel | input | 2 | Polarity selector; bit 1 for pins A/C, bit 0 for pins B/D |
| shutdown | input | 1 | Auto-shutdown request |
| port_data | input | 4 | Port values for unsteered pins |
| pin_out | output | 4 | Pin values |

## Verification
The bench builds the block with its default parameters: four pins, an eight-bit register and a reset value of 0x01. With these values every mask combination and every polarity pairing can be reached in a short run. The sync bit lands at bit 4, so a pending update and the period strobe that releases it can be lined up cycle by cycle, including a strobe that arrives in the same cycle as an immediate write.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  localparam int unsigned POL_W = 2;

  // Inversion bit for a pin: even pins follow the upper selector bit,
  // odd pins follow the lower selector bit.
  function automatic logic pin_invert(input logic [POL_W-1:0] pol,
                                      input int unsigned idx);
    return (idx % 2 == 0) ? pol[1] : pol[0];
  endfunction

  // Value a pin drives given its steering state and inputs.
  function automatic logic pin_value(input logic steered,
                                     input logic inv,
                                     input logic pwm,
                                     input logic off,
                                     input logic port);
    logic v;
    if (!steered)  v = port;
    else if (off)  v = inv;
    else           v = pwm ^ inv;
    return v;
  endfunction

  // Implemented-bit mask for a register that holds a mask and one sync bit.
  function automatic logic [31:0] impl_bits(input int unsigned mask_w);
    return (32'd1 << (mask_w + 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/steer_cfg_reg.sv
module steer_cfg_reg #(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned MASK_W    = 4,
  parameter logic [REG_W-1:0] RST_VAL = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_q
);
  import pwm_steer_pkg::*;

  localparam logic [REG_W-1:0] IMPL = REG_W'(impl_bits(MASK_W));

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= RST_VAL & IMPL;
    else if (wr_en) cfg_q <= wr_data & IMPL;
  end
endmodule

// File: rtl/steer_mask_sel.sv
module steer_mask_sel #(
  parameter int unsigned MASK_W = 4,
  parameter logic [MASK_W-1:0] RST_MASK = 4'b0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imm_load,
  input  logic [MASK_W-1:0] imm_mask,
  input  logic              sync_load,
  input  logic [MASK_W-1:0] pend_mask,
  output logic [MASK_W-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         act_q <= RST_MASK;
    else if (imm_load)  act_q <= imm_mask;
    else if (sync_load) act_q <= pend_mask;
  end
endmodule

// File: rtl/steer_pin_drv.sv
module steer_pin_drv #(
  parameter int unsigned IDX = 0
) (
  input  logic                              steered,
  input  logic [pwm_steer_pkg::POL_W-1:0]   pol_sel,
  input  logic                              pwm_in,
  input  logic                              shutdown,
  input  logic                              port_bit,
  output logic                              pin
);
  import pwm_steer_pkg::*;

  logic inv;
  always_comb begin
    inv = pin_invert(pol_sel, IDX);
    pin = pin_value(steered, inv, pwm_in, shutdown, port_bit);
  end
endmodule

// File: rtl/pwm_steer_unit.sv
module pwm_steer_unit #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned REG_W    = 8,
  parameter logic [REG_W-1:0] RST_VAL = 8'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic                pwm_in,
  input  logic                period_start,
  input  logic                single_mode,
  input  logic [1:0]          pol_sel,
  input  logic                shutdown,
  input  logic [NUM_PINS-1:0] port_data,
  output logic [NUM_PINS-1:0] pin_out
);
  localparam int unsigned SYNC_BIT = NUM_PINS;

  logic [REG_W-1:0]    cfg_q;
  logic [NUM_PINS-1:0] act_mask;
  logic [NUM_PINS-1:0] eff_mask;
  logic                imm_load;
  logic                sync_load;

  assign imm_load  = wr_en && !wr_data[SYNC_BIT];
  assign sync_load = period_start && cfg_q[SYNC_BIT];
  assign eff_mask  = act_mask & {NUM_PINS{single_mode}};
  assign rd_data   = cfg_q;

  steer_cfg_reg #(.REG_W(REG_W), .MASK_W(NUM_PINS), .RST_VAL(RST_VAL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q)
  );

  steer_mask_sel #(.MASK_W(NUM_PINS), .RST_MASK(RST_VAL[NUM_PINS-1:0])) u_sel (
    .clk(clk), .rst_n(rst_n),
    .imm_load(imm_load), .imm_mask(wr_data[NUM_PINS-1:0]),
    .sync_load(sync_load), .pend_mask(cfg_q[NUM_PINS-1:0]),
    .act_q(act_mask)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    steer_pin_drv #(.IDX(g)) u_drv (
      .steered(eff_mask[g]), .pol_sel(pol_sel), .pwm_in(pwm_in),
      .shutdown(shutdown), .port_bit(port_data[g]), .pin(pin_out[g])
    );
  end
endmodule

// File: rtl/pwm_steer_unit_chk.sv
module pwm_steer_unit_chk #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned REG_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [REG_W-1:0]    wr_data,
  input logic [REG_W-1:0]    rd_data,
  input logic                period_start,
  input logic                single_mode,
  input logic [1:0]          pol_sel,
  input logic                shutdown,
  input logic [NUM_PINS-1:0] port_data,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] act_mask,
  input logic                imm_load,
  input logic                sync_load
);
  localparam int unsigned SB = NUM_PINS;

  logic [NUM_PINS-1:0] inv_vec;
  always_comb
    for (int i = 0; i < NUM_PINS; i++) inv_vec[i] = (i % 2 == 0) ? pol_sel[1] : pol_sel[0];

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[SB:0] == $past(wr_data[SB:0]));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:SB+1] == '0);
  a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[SB]) |=> act_mask == $past(wr_data[NUM_PINS-1:0]));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_load && !sync_load) |=> $stable(act_mask));
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !wr_data[SB]) && period_start && rd_data[SB])
      |=> act_mask == $past(rd_data[NUM_PINS-1:0]));
  a_r6_port: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~act_mask) == (port_data & ~act_mask)));
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !single_mode |-> pin_out == port_data);
  a_r10_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && shutdown) |-> ((pin_out ^ inv_vec) & act_mask) == '0);
endmodule

bind pwm_steer_unit pwm_steer_unit_chk #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .period_start(period_start), .single_mode(single_mode), .pol_sel(pol_sel),
  .shutdown(shutdown), .port_data(port_data), .pin_out(pin_out),
  .act_mask(act_mask), .imm_load(imm_load), .sync_load(sync_load)
);

// File: tb/pwm_steer_unit_tb.sv
module pwm_steer_unit_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       pwm_in = 0;
  logic       period_start = 0;
  logic       single_mode = 1;
  logic [1:0] pol_sel = 0;
  logic       shutdown = 0;
  logic [3:0] port_data = 0;
  logic [3:0] pin_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int m_reg = 1;
  int m_act = 1;
  int lfsr = 32'h1ace;

  always #2 clk = ~clk;

  pwm_steer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pwm_in(pwm_in), .period_start(period_start), .single_mode(single_mode),
    .pol_sel(pol_sel), .shutdown(shutdown), .port_data(port_data), .pin_out(pin_out)
  );

  // Behavioural reference: register and active mask as integers.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg <= 1; m_act <= 1;
    end else begin
      if (wr_en) m_reg <= wr_data % 32;
      if (wr_en && wr_data[4] == 0) m_act <= wr_data % 16;
      else if (period_start && (m_reg / 16) % 2 == 1) m_act <= m_reg % 16;
    end
  end

  function automatic int exp_pins();
    int r = 0;
    for (int i = 0; i < 4; i++) begin
      int inv = (i == 0 || i == 2) ? pol_sel[1] : pol_sel[0];
      int v;
      if (single_mode && ((m_act >> i) % 2 == 1)) v = shutdown ? inv : (pwm_in ^ inv);
      else v = port_data[i];
      r += v << i;
    end
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) if (rst_n) begin
    check(cur_req, int'(pin_out), exp_pins());
    check(cur_req, int'(rd_data), m_reg);
  end

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      lfsr = (lfsr >> 1) ^ ((lfsr % 2 == 1) ? 32'hB400 : 0);
      pwm_in = lfsr[0];
      wr_en = 0; period_start = 0;
    end
  endtask

  task automatic write(logic [7:0] v);
    wr_en = 1; wr_data = v;
    step(1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3); rst_n = 1; #1;
    @(negedge clk);
    check("R1", int'(rd_data), 8'h01);
    pwm_in = 1; port_data = 4'b0000; #0.5;
    check("R1", int'(pin_out), 4'b0001);
    step(6);

    cur_req = "R11"; port_data = 4'b1010;
    write(8'h02); pwm_in = 1; #0.5;
    check("R3", int'(pin_out), 4'b1011 & 4'b1110 | 4'b0010); // pin B steered high, A shows port 0
    step(6);

    cur_req = "R8"; write(8'h0F); step(10);
    cur_req = "R7";
    for (int p = 0; p < 4; p++) begin pol_sel = p[1:0]; step(6); end
    pwm_in = 0; pol_sel = 2'b10; #0.5;
    check("R7", int'(pin_out), 4'b0101);

    cur_req = "R6"; pol_sel = 0; write(8'h05);
    for (int d = 0; d < 16; d++) begin port_data = d[3:0]; step(1); end

    cur_req = "R4"; port_data = 4'b0000; write(8'h1A);
    pwm_in = 1; #0.5;
    check("R5", int'(rd_data), 8'h1A);
    check("R4", int'(pin_out), 4'b0101);
    step(5);
    period_start = 1; step(1); pwm_in = 1; #0.5;
    check("R4", int'(pin_out), 4'b1010);
    step(4);
    cur_req = "R4"; write(8'h13); wr_en = 1; wr_data = 8'h04; period_start = 1;
    step(1); step(4);

    cur_req = "R2"; write(8'hFF); #0.5;
    check("R2", int'(rd_data), 8'h1F);
    write(8'hE6); step(3);

    cur_req = "R9"; single_mode = 0; port_data = 4'b0110; write(8'h0F);
    shutdown = 1; step(5); shutdown = 0; step(5);
    single_mode = 1;

    cur_req = "R10"; write(8'h06); port_data = 4'b1001;
    for (int p = 0; p < 4; p++) begin pol_sel = p[1:0]; shutdown = 1; step(3); shutdown = 0; step(2); end
    pol_sel = 2'b01; shutdown = 1; #0.5;
    check("R10", int'(pin_out), 4'b1011);
    shutdown = 0;

    cur_req = "R4";
    for (int k = 0; k < 400; k++) begin
      wr_en = ($urandom % 5 == 0);
      wr_data = 8'($urandom);
      period_start = ($urandom % 7 == 0);
      single_mode = ($urandom % 8 != 0);
      shutdown = ($urandom % 6 == 0);
      pol_sel = 2'($urandom);
      port_data = 4'($urandom);
      pwm_in = $urandom % 2;
      @(posedge clk); #1;
    end
    wr_en = 0; period_start = 0;
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule